// File: doc/BRIEF.md
# Start-Aligned Serial Word Receiver with Carrier Unmasking

This block is the receive end of a masked serial link. It watches an asynchronous serial line, assembles a multi-byte word from consecutive characters, and removes an additive carrier sample from that word to recover the payload. The bit-timing counter is not free-running. Every falling start edge reloads it, so each character is sampled from its own start edge and small rate differences do not accumulate across a word.

Each character is framed by a low start bit and a high stop bit. Bytes fill the word starting at the least significant lane. When the last lane is filled, the receiver raises a one-cycle ready strobe with the full word. A small controller waits in a synchronization state for that strobe. It then subtracts a carrier value supplied by a local generator and publishes the result with a one-cycle valid strobe. Next it counts a fixed hold-off interval and emits a one-cycle advance strobe that paces the local generator's next step.

Top module: `rx_demask`

## Requirements
- R1: During and immediately after reset, word_ready, data_valid and gen_advance are 0, and rx_word and data_out are all zeros.
- R2: A character is a low start bit, then eight data bits with the least significant bit first, then a high stop bit, each bit lasting CLK_PER_BIT clocks. The first accepted character of a word lands in rx_word[7:0] and character k lands in rx_word[8k+7:8k].
- R3: word_ready is high for exactly one clock once WORD_BYTES characters have been accepted. rx_word holds that word until the next word completes.
- R4: Every detected start edge restarts the bit timer, so characters separated by any number of idle clocks are received correctly.
- R5: A character whose stop bit samples low is discarded, and word assembly restarts at the lowest lane.
- R6: A low pulse on the line that is no longer high at the mid-start sample is rejected and contributes no character.
- R7: The controller waits in its synchronization state until word_ready. Exactly two clocks after word_ready it pulses data_valid for one clock, with data_out equal to rx_word minus carrier modulo 2^32. carrier is sampled one clock after word_ready.
- R8: gen_advance pulses for one clock exactly HOLD_CYCLES clocks after data_valid. The default is 33.
- R9: A word_ready that arrives while the controller is in its demodulation or hold-off state is ignored and produces no data_valid. A word_ready in the same clock as gen_advance is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial line, idle high |
| carrier | input | 8*WORD_BYTES | Local carrier sample to remove |
| rx_word | output | 8*WORD_BYTES | Last fully assembled word |
| word_ready | output | 1 | One-clock strobe when rx_word is new |
| data_out | output | 8*WORD_BYTES | Recovered payload (rx_word minus carrier) |
| data_valid | output | 1 | One-clock strobe when data_out is new |
| gen_advance | output | 1 | One-clock strobe pacing the next generator step |

## Verification
Word completion in the receiver and the end of the controller's hold-off can land in the same clock. That case decides whether a word is kept or lost. The bench provokes it with two back-to-back words on an instance that has a long hold-off. The idle gap between the words is computed so that the second word_ready falls first one clock before gen_advance, and then exactly with it. The first case must yield no data_valid for the second word. The second case must yield its recovered value, with word_ready and gen_advance observed in the same cycle.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

   typedef enum logic [1:0] {
      CT_SYNC  = 2'd0,
      CT_DEMOD = 2'd1,
      CT_HOLD  = 2'd2
   } ctrl_state_t;

   function automatic int unsigned mid_offset(input int unsigned clk_per_bit);
      return clk_per_bit / 2;
   endfunction

endpackage

// File: rtl/rxd_sync.sv
module rxd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_q,
   output logic fall
);
   logic [STAGES-1:0] pipe;
   logic              prev;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[0] <= 1'b1;
            else        pipe[0] <= line_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= 1'b1;
            else        pipe[g] <= pipe[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= pipe[STAGES-1];
   end

   assign line_q = pipe[STAGES-1];
   assign fall   = prev & ~pipe[STAGES-1];
endmodule

// File: rtl/rxd_char.sv
module rxd_char
   import rxd_pkg::*;
#(
   parameter int CLK_PER_BIT = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_q,
   input  logic       fall,
   output logic       char_ok,
   output logic       char_bad,
   output logic [7:0] char_data
);
   localparam int CW   = $clog2(CLK_PER_BIT);
   localparam int HALF = int'(mid_offset(CLK_PER_BIT));

   logic          busy;
   logic [CW-1:0] cnt;
   logic [3:0]    idx;
   logic [7:0]    shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt      <= '0;
         idx      <= '0;
         shreg    <= '0;
         char_ok  <= 1'b0;
         char_bad <= 1'b0;
      end else begin
         char_ok  <= 1'b0;
         char_bad <= 1'b0;
         if (!busy) begin
            if (fall) begin
               busy <= 1'b1;
               cnt  <= CW'(HALF - 1);
               idx  <= 4'd0;
            end
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end else begin
            cnt <= CW'(CLK_PER_BIT - 1);
            idx <= idx + 4'd1;
            if (idx == 4'd0) begin
               if (line_q) busy <= 1'b0;
            end else if (idx <= 4'd8) begin
               shreg <= {line_q, shreg[7:1]};
            end else begin
               busy <= 1'b0;
               if (line_q) char_ok  <= 1'b1;
               else        char_bad <= 1'b1;
            end
         end
      end
   end

   assign char_data = shreg;
endmodule

// File: rtl/rxd_word.sv
module rxd_word #(
   parameter int BYTES = 4,
   localparam int W    = 8 * BYTES
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         char_ok,
   input  logic         char_bad,
   input  logic [7:0]   char_data,
   output logic [W-1:0] word,
   output logic         ready
);
   localparam int IW = $clog2(BYTES);

   logic [IW-1:0] slot;
   logic [W-1:0]  acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot  <= '0;
         acc   <= '0;
         word  <= '0;
         ready <= 1'b0;
      end else begin
         ready <= 1'b0;
         if (char_bad) begin
            slot <= '0;
         end else if (char_ok) begin
            if (slot == IW'(BYTES - 1)) begin
               word[W-1 -: 8] <= char_data;
               word[W-9:0]    <= acc[W-9:0];
               ready          <= 1'b1;
               slot           <= '0;
            end else begin
               acc[slot*8 +: 8] <= char_data;
               slot             <= slot + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
   import rxd_pkg::*;
#(
   parameter int W    = 32,
   parameter int HOLD = 33
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         word_ready,
   input  logic [W-1:0] rx_word,
   input  logic [W-1:0] carrier,
   output logic [W-1:0] data_out,
   output logic         data_valid,
   output logic         gen_advance
);
   localparam int HW = $clog2(HOLD + 1);

   ctrl_state_t   state;
   logic [W-1:0]  held;
   logic [HW-1:0] hcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= CT_SYNC;
         held        <= '0;
         hcnt        <= '0;
         data_out    <= '0;
         data_valid  <= 1'b0;
         gen_advance <= 1'b0;
      end else begin
         data_valid  <= 1'b0;
         gen_advance <= 1'b0;
         unique case (state)
            CT_SYNC: begin
               if (word_ready) begin
                  held  <= rx_word;
                  state <= CT_DEMOD;
               end
            end
            CT_DEMOD: begin
               data_out   <= held - carrier;
               data_valid <= 1'b1;
               hcnt       <= '0;
               state      <= CT_HOLD;
            end
            CT_HOLD: begin
               if (hcnt == HW'(HOLD - 1)) begin
                  gen_advance <= 1'b1;
                  state       <= CT_SYNC;
               end else begin
                  hcnt <= hcnt + 1'b1;
               end
            end
            default: state <= CT_SYNC;
         endcase
      end
   end
endmodule

// File: rtl/rx_demask.sv
module rx_demask #(
   parameter int CLK_PER_BIT = 16,
   parameter int WORD_BYTES  = 4,
   parameter int HOLD_CYCLES = 33,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rx_line,
   input  logic [8*WORD_BYTES-1:0] carrier,
   output logic [8*WORD_BYTES-1:0] rx_word,
   output logic                    word_ready,
   output logic [8*WORD_BYTES-1:0] data_out,
   output logic                    data_valid,
   output logic                    gen_advance
);
   localparam int W = 8 * WORD_BYTES;

   if (CLK_PER_BIT < 4) begin : g_chk_cpb
      $error("rx_demask: CLK_PER_BIT must be at least 4");
   end
   if (WORD_BYTES < 2) begin : g_chk_bytes
      $error("rx_demask: WORD_BYTES must be at least 2");
   end
   if (HOLD_CYCLES < 1) begin : g_chk_hold
      $error("rx_demask: HOLD_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("rx_demask: SYNC_STAGES must be at least 2");
   end

   logic       line_q, fall;
   logic       char_ok, char_bad;
   logic [7:0] char_data;

   rxd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_in(rx_line),
      .line_q(line_q), .fall(fall)
   );

   rxd_char #(.CLK_PER_BIT(CLK_PER_BIT)) u_char (
      .clk(clk), .rst_n(rst_n), .line_q(line_q), .fall(fall),
      .char_ok(char_ok), .char_bad(char_bad), .char_data(char_data)
   );

   rxd_word #(.BYTES(WORD_BYTES)) u_word (
      .clk(clk), .rst_n(rst_n), .char_ok(char_ok), .char_bad(char_bad),
      .char_data(char_data), .word(rx_word), .ready(word_ready)
   );

   rxd_ctrl #(.W(W), .HOLD(HOLD_CYCLES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .word_ready(word_ready), .rx_word(rx_word),
      .carrier(carrier), .data_out(data_out), .data_valid(data_valid),
      .gen_advance(gen_advance)
   );
endmodule

// File: rtl/rx_demask_chk.sv
module rx_demask_chk #(
   parameter int HOLD_CYCLES = 33
) (
   input logic clk,
   input logic rst_n,
   input logic word_ready,
   input logic data_valid,
   input logic gen_advance
);
   logic [31:0] since_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                            since_valid <= '0;
      else if (data_valid)                                   since_valid <= 32'd1;
      else if (since_valid != '0 && since_valid != '1)       since_valid <= since_valid + 32'd1;
   end

   assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      word_ready |=> !word_ready);

   assert_valid_after_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> $past(word_ready, 2));

   assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |=> !data_valid);

   assert_advance_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gen_advance |=> !gen_advance);

   assert_hold_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gen_advance |-> since_valid == 32'(HOLD_CYCLES));

   assert_strobes_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({data_valid, gen_advance}));

   assert_no_valid_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> (since_valid == '0 || since_valid > 32'(HOLD_CYCLES)));
endmodule

bind rx_demask rx_demask_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .word_ready(word_ready),
   .data_valid(data_valid), .gen_advance(gen_advance)
);

// File: tb/rx_demask_test.sv
module rx_demask_test;
   localparam int B     = 4;
   localparam int HOLDS = 33;
   localparam int HOLDL = 170;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_line = 1'b1;
   logic [31:0] carrier = '0;

   logic [31:0] w_a, d_a, w_b, d_b;
   logic        r_a, v_a, g_a, r_b, v_b, g_b;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   always #10ns clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rx_demask #(.CLK_PER_BIT(B), .WORD_BYTES(4), .HOLD_CYCLES(HOLDS)) uut (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .carrier(carrier),
      .rx_word(w_a), .word_ready(r_a), .data_out(d_a), .data_valid(v_a), .gen_advance(g_a));

   rx_demask #(.CLK_PER_BIT(B), .WORD_BYTES(4), .HOLD_CYCLES(HOLDL)) uut_edge (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .carrier(carrier),
      .rx_word(w_b), .word_ready(r_b), .data_out(d_b), .data_valid(v_b), .gen_advance(g_b));

   // event logs per instance (0 = uut, 1 = uut_edge)
   int          rn[2], vn[2], an[2], wide[2];
   int          rcyc[2][64], vcyc[2][64], acyc[2][64];
   logic [31:0] vdat[2][64];
   logic        rprev[2], vprev[2], aprev[2];

   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 2; i++) begin
            logic rr, vv, gg;
            logic [31:0] dd;
            rr = (i == 0) ? r_a : r_b;
            vv = (i == 0) ? v_a : v_b;
            gg = (i == 0) ? g_a : g_b;
            dd = (i == 0) ? d_a : d_b;
            if (rr) begin
               if (rprev[i]) wide[i]++;
               if (rn[i] < 64) rcyc[i][rn[i]] = cyc;
               rn[i]++;
            end
            if (vv) begin
               if (vprev[i]) wide[i]++;
               if (vn[i] < 64) begin vcyc[i][vn[i]] = cyc; vdat[i][vn[i]] = dd; end
               vn[i]++;
            end
            if (gg) begin
               if (aprev[i]) wide[i]++;
               if (an[i] < 64) acyc[i][an[i]] = cyc;
               an[i]++;
            end
            rprev[i] = rr; vprev[i] = vv; aprev[i] = gg;
         end
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hold_line(input logic v, input int n);
      rx_line = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] b, input logic stop);
      hold_line(1'b0, B);
      for (int i = 0; i < 8; i++) hold_line(b[i], B);
      hold_line(stop, B);
   endtask

   task automatic send_word(input logic [31:0] w, input int gap);
      for (int k = 0; k < 4; k++) begin
         send_char(w[8*k +: 8], 1'b1);
         if (k < 3 && gap > 0) hold_line(1'b1, gap);
      end
   endtask

   // verify the most recent word on instance i
   task automatic verify_last(input int i, input logic [31:0] w, input logic [31:0] c,
                              input int hold, input int er, input int ev);
      int r, v;
      r = rn[i] - 1; v = vn[i] - 1;
      check(rn[i] == er, "R3 ready count", 32'(rn[i]), 32'(er));
      check(((i == 0) ? w_a : w_b) == w, "R2 word assembly", (i == 0) ? w_a : w_b, w);
      check(vn[i] == ev, "R7 valid count", 32'(vn[i]), 32'(ev));
      check(vdat[i][v] == w - c, "R7 unmasked data", vdat[i][v], w - c);
      check(vcyc[i][v] - rcyc[i][r] == 2, "R7 valid latency", 32'(vcyc[i][v] - rcyc[i][r]), 32'd2);
      check(acyc[i][v] - vcyc[i][v] == hold, "R8 advance spacing", 32'(acyc[i][v] - vcyc[i][v]), 32'(hold));
   endtask

   initial begin
      #(20ns * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] w, c;
      int er0, ev0, er1, ev1, g_at;
      for (int i = 0; i < 2; i++) begin
         rn[i] = 0; vn[i] = 0; an[i] = 0; wide[i] = 0;
         rprev[i] = 0; vprev[i] = 0; aprev[i] = 0;
      end
      repeat (4) @(negedge clk);
      // R1: reset state
      check(!r_a && !v_a && !g_a, "R1 strobes in reset", {29'd0, r_a, v_a, g_a}, 32'd0);
      check(w_a == 0 && d_a == 0, "R1 words in reset", w_a | d_a, 32'd0);
      rst_n = 1'b1;
      repeat (8) @(negedge clk);
      check(!r_b && !v_b && !g_b && w_b == 0 && d_b == 0, "R1 after reset",
            {29'd0, r_b, v_b, g_b} | w_b | d_b, 32'd0);

      // R2 R4 R7 R8: sweep over patterns, carriers and inter-character gaps
      er0 = 0; ev0 = 0; er1 = 0; ev1 = 0;
      for (int i = 0; i < 12; i++) begin
         case (i)
            0: w = 32'h0000_0000;
            1: w = 32'hFFFF_FFFF;
            2: w = 32'h8000_0001;
            3: w = 32'h0123_4567;
            default: w = (32'h1 << (i * 3 - 7)) ^ (32'hA5C3_0F96 * i);
         endcase
         c = (i % 3 == 0) ? 32'hFFFF_FFF0 - 32'(i) : 32'h1357_9BDF * (i + 1);
         carrier = c;
         send_word(w, i % 6);
         hold_line(1'b1, 240);
         er0++; ev0++; er1++; ev1++;
         verify_last(0, w, c, HOLDS, er0, ev0);
         verify_last(1, w, c, HOLDL, er1, ev1);
      end

      // R4: uneven idle gaps between characters (7 clocks, then 1, then 13)
      w = 32'hC0FF_EE42; c = 32'h0000_1000; carrier = c;
      send_char(w[7:0], 1'b1);   hold_line(1'b1, 7);
      send_char(w[15:8], 1'b1);  hold_line(1'b1, 1);
      send_char(w[23:16], 1'b1); hold_line(1'b1, 13);
      send_char(w[31:24], 1'b1);
      hold_line(1'b1, 240);
      er0++; ev0++; er1++; ev1++;
      check(w_a == w, "R4 realigned word", w_a, w);
      verify_last(0, w, c, HOLDS, er0, ev0);

      // R5: good char, bad stop char, then a full word: the first char must not count
      w = 32'h7E3C_1899; c = 32'h1111_1111; carrier = c;
      send_char(8'hAB, 1'b1);
      send_char(8'hCD, 1'b0);
      hold_line(1'b1, 3 * B);
      send_word(w, 2);
      hold_line(1'b1, 240);
      er0++; ev0++; er1++; ev1++;
      check(w_a == w, "R5 bad stop restarts assembly", w_a, w);
      check(rn[0] == er0, "R5 single ready", 32'(rn[0]), 32'(er0));
      verify_last(0, w, c, HOLDS, er0, ev0);

      // R6: one-clock low glitch before a word contributes no character
      w = 32'h5A5A_0F0F; c = 32'h0000_0001; carrier = c;
      hold_line(1'b0, 1);
      hold_line(1'b1, 3 * B);
      send_word(w, 0);
      hold_line(1'b1, 240);
      er0++; ev0++; er1++; ev1++;
      check(w_a == w, "R6 glitch rejected", w_a, w);
      verify_last(1, w, c, HOLDL, er1, ev1);

      // R9: second word's ready lands one clock before the long hold ends -> ignored
      g_at = HOLDL + 1 - 40 * B;
      c = 32'h0F0F_0F0F; carrier = c;
      send_word(32'h1122_3344, 0);
      hold_line(1'b1, g_at);
      send_word(32'h5566_7788, 0);
      hold_line(1'b1, 400);
      er1 += 2; ev1++;
      check(rn[1] == er1, "R9 both words assembled", 32'(rn[1]), 32'(er1));
      check(vn[1] == ev1, "R9 ready in hold ignored", 32'(vn[1]), 32'(ev1));
      check(vdat[1][vn[1]-1] == 32'h1122_3344 - c, "R9 kept first word", vdat[1][vn[1]-1], 32'h1122_3344 - c);
      check(rcyc[1][rn[1]-1] == acyc[1][an[1]-1] - 1, "R9 dropped ready timing",
            32'(rcyc[1][rn[1]-1]), 32'(acyc[1][an[1]-1] - 1));
      er0 += 2; ev0 += 2;
      check(vn[0] == ev0, "R9 short hold accepts both", 32'(vn[0]), 32'(ev0));

      // R9: ready coincides with gen_advance -> accepted
      carrier = c;
      send_word(32'h99AA_BBCC, 0);
      hold_line(1'b1, g_at + 1);
      send_word(32'hDDEE_FF00, 0);
      hold_line(1'b1, 400);
      er1 += 2; ev1 += 2;
      check(vn[1] == ev1, "R9 coincident ready accepted", 32'(vn[1]), 32'(ev1));
      check(vdat[1][vn[1]-1] == 32'hDDEE_FF00 - c, "R9 coincident data", vdat[1][vn[1]-1], 32'hDDEE_FF00 - c);
      check(rcyc[1][rn[1]-1] == acyc[1][an[1]-2], "R9 same-cycle ready and advance",
            32'(rcyc[1][rn[1]-1]), 32'(acyc[1][an[1]-2]));

      // R3 R7 R8: every strobe seen was a single-clock pulse
      check(wide[0] == 0 && wide[1] == 0, "R3 single-clock strobes", 32'(wide[0] + wide[1]), 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule